// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, given as a segment number plus an offset, into a physical address. It checks the request against a small segment table held in registers. Each table entry gives a segment's physical start address, its length in bytes, a valid flag and three permission flags: read, write and execute. A length register sets how many segment numbers are legal.

A requester presents the segment number, the offset and the access type with a one-cycle strobe. One cycle later the block returns one of two results. On success it gives the physical address and raises a memory request. On failure it raises a fault with a cause code. Software fills the table and the length register through a synchronous write port. A lookup always reads the table as it stood before any write in the same cycle.

Top module: `seg_xlate`

## Requirements
- R1: While rst_ni is low, and after it is released, rsp_valid_o, rsp_fault_o, mem_req_o, rsp_cause_o and rsp_paddr_o are all zero. After reset the length register is 0 and every entry is invalid.
- R2: rsp_valid_o is high in the cycle after a cycle in which req_valid_i is high, and low in every other cycle.
- R3: A request whose segment number is greater than or equal to the length register faults with cause 2'b01.
- R4: A request to an entry whose valid flag is 0 faults with cause 2'b10.
- R5: The offset must be strictly less than the entry's limit. When it is not, the request faults with cause 2'b10. A limit of 0 rejects every offset.
- R6: Access type 2'b00 is read and needs perm bit 0. Type 2'b01 is write and needs perm bit 1. Type 2'b10 is execute and needs perm bit 2. Type 2'b11 is never permitted. A missing permission faults with cause 2'b11.
- R7: When several checks fail, the reported cause follows this priority: first 2'b01, then 2'b10, then 2'b11.
- R8: A request that passes every check returns rsp_fault_o=0, cause 2'b00, mem_req_o=1 and rsp_paddr_o = base + offset, kept to PA_W bits.
- R9: A faulting request returns rsp_fault_o=1, rsp_paddr_o=0 and mem_req_o=0.
- R10: A table or length write made in the same cycle as a request does not affect that request. It applies to the next request.
- R11: When cfg_len_sel_i=1, a write updates only the length register. When it is 0, the write updates only the entry selected by cfg_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_seg_i | input | SEG_W | Segment number |
| req_ofs_i | input | OFS_W | Offset within the segment |
| req_acc_i | input | 2 | Access type |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_len_sel_i | input | 1 | 1: write the length register, 0: write a table entry |
| cfg_idx_i | input | SEG_W | Index of the entry to write |
| cfg_base_i | input | PA_W | Base value for the entry |
| cfg_limit_i | input | OFS_W+1 | Limit value for the entry |
| cfg_valid_i | input | 1 | Valid flag for the entry |
| cfg_perm_i | input | 3 | Permission bits: bit 0 read, bit 1 write, bit 2 execute |
| cfg_len_i | input | SEG_W+1 | Value for the length register |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 1 | Fault flag |
| rsp_cause_o | output | 2 | Fault cause code |
| rsp_paddr_o | output | PA_W | Physical address |
| mem_req_o | output | 1 | Memory request for a successful translation |

## Verification
A configuration write and a lookup can happen in the same clock cycle. The bench provokes this by driving, on one clock edge, a request to a segment together with a write that changes that segment. In one case the write makes an invalid entry valid. In another it raises the length register past the requested segment number. The same-cycle request must report the fault that the old table state implies. The bench then sends an identical request in the following cycle, which must see the new state.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_RANGE = 2'b01,
    CAUSE_BOUND = 2'b10,
    CAUSE_PERM  = 2'b11
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFS_W = 12,
  parameter int PA_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               len_sel_i,
  input  logic [SEG_W-1:0]   wr_idx_i,
  input  logic [PA_W-1:0]    wr_base_i,
  input  logic [OFS_W:0]     wr_limit_i,
  input  logic               wr_valid_i,
  input  logic [PERM_W-1:0]  wr_perm_i,
  input  logic [SEG_W:0]     wr_len_i,
  input  logic [SEG_W-1:0]   rd_idx_i,
  output logic [PA_W-1:0]    rd_base_o,
  output logic [OFS_W:0]     rd_limit_o,
  output logic               rd_valid_o,
  output logic [PERM_W-1:0]  rd_perm_o,
  output logic [SEG_W:0]     len_o
);
  localparam int NUM_SEG = 1 << SEG_W;

  logic [PA_W-1:0]   base_q  [NUM_SEG];
  logic [OFS_W:0]    limit_q [NUM_SEG];
  logic [PERM_W-1:0] perm_q  [NUM_SEG];
  logic [NUM_SEG-1:0] valid_q;
  logic [SEG_W:0]    len_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    logic hit;
    assign hit = we_i && !len_sel_i && (wr_idx_i == SEG_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        perm_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (hit) begin
        base_q[g]  <= wr_base_i;
        limit_q[g] <= wr_limit_i;
        perm_q[g]  <= wr_perm_i;
        valid_q[g] <= wr_valid_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                len_q <= '0;
    else if (we_i && len_sel_i) len_q <= wr_len_i;
  end

  // read port sees pre-write state; writes land at the edge
  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_limit_o = limit_q[rd_idx_i];
  assign rd_perm_o  = perm_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign len_o      = len_q;

  assert_entry_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !len_sel_i) |=> (valid_q[$past(wr_idx_i)] == $past(wr_valid_i)) && $stable(len_q));

  assert_len_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && len_sel_i) |=> (len_q == $past(wr_len_i)) && $stable(valid_q));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFS_W = 12,
  parameter int PA_W  = 16
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [1:0]        acc_i,
  input  logic [SEG_W:0]    len_i,
  input  logic [PA_W-1:0]   base_i,
  input  logic [OFS_W:0]    limit_i,
  input  logic              valid_i,
  input  logic [PERM_W-1:0] perm_i,
  output cause_e            cause_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic in_range, in_bound, allowed;

  assign in_range = {1'b0, seg_i} < len_i;
  assign in_bound = valid_i && ({1'b0, ofs_i} < limit_i);

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  allowed = perm_i[PERM_RD];
      ACC_WRITE: allowed = perm_i[PERM_WR];
      ACC_EXEC:  allowed = perm_i[PERM_EX];
      default:   allowed = 1'b0;
    endcase
  end

  // priority: range, then valid/limit, then permission
  always_comb begin
    if (!in_range)      cause_o = CAUSE_RANGE;
    else if (!in_bound) cause_o = CAUSE_BOUND;
    else if (!allowed)  cause_o = CAUSE_PERM;
    else                cause_o = CAUSE_NONE;
  end

  assign paddr_o = base_i + PA_W'(ofs_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFS_W = 12,
  parameter int PA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFS_W-1:0]  req_ofs_i,
  input  logic [1:0]        req_acc_i,
  input  logic              cfg_we_i,
  input  logic              cfg_len_sel_i,
  input  logic [SEG_W-1:0]  cfg_idx_i,
  input  logic [PA_W-1:0]   cfg_base_i,
  input  logic [OFS_W:0]    cfg_limit_i,
  input  logic              cfg_valid_i,
  input  logic [2:0]        cfg_perm_i,
  input  logic [SEG_W:0]    cfg_len_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_cause_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              mem_req_o
);
  logic [PA_W-1:0]   ent_base;
  logic [OFS_W:0]    ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  logic [SEG_W:0]    tbl_len;
  cause_e            chk_cause;
  logic [PA_W-1:0]   chk_paddr;

  seg_table #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .len_sel_i  (cfg_len_sel_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_base_i  (cfg_base_i),
    .wr_limit_i (cfg_limit_i),
    .wr_valid_i (cfg_valid_i),
    .wr_perm_i  (cfg_perm_i),
    .wr_len_i   (cfg_len_i),
    .rd_idx_i   (req_seg_i),
    .rd_base_o  (ent_base),
    .rd_limit_o (ent_limit),
    .rd_valid_o (ent_valid),
    .rd_perm_o  (ent_perm),
    .len_o      (tbl_len)
  );

  seg_check #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_check (
    .seg_i   (req_seg_i),
    .ofs_i   (req_ofs_i),
    .acc_i   (req_acc_i),
    .len_i   (tbl_len),
    .base_i  (ent_base),
    .limit_i (ent_limit),
    .valid_i (ent_valid),
    .perm_i  (ent_perm),
    .cause_o (chk_cause),
    .paddr_o (chk_paddr)
  );

  logic fault_d;
  assign fault_d = (chk_cause != CAUSE_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_cause_o <= 2'b00;
      rsp_paddr_o <= '0;
      mem_req_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i && fault_d;
      rsp_cause_o <= req_valid_i ? chk_cause : CAUSE_NONE;
      rsp_paddr_o <= (req_valid_i && !fault_d) ? chk_paddr : '0;
      mem_req_o   <= req_valid_i && !fault_d;
    end
  end

  assert_rsp_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !mem_req_o && !rsp_fault_o);
  assert_range_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ({1'b0, req_seg_i} >= tbl_len)) |=> rsp_cause_o == 2'b01);
  assert_fault_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0) && !mem_req_o);
  assert_invalid_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ({1'b0, req_seg_i} < tbl_len) && !ent_valid) |=> rsp_cause_o == 2'b10);
  assert_good_paddr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mem_req_o == 1'b0 && !fault_d) |=>
      mem_req_o && rsp_paddr_o == $past(ent_base + PA_W'(req_ofs_i)));
endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 3;
  localparam int OFS_W = 12;
  localparam int PA_W  = 16;
  localparam int NV    = 14;

  // {seg[3], ofs[12], acc[2], cause[2], paddr[16]}
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 12'h000, 2'd0, 2'd0, 16'h1000},  // R8 read
    {3'd0, 12'h0FF, 2'd2, 2'd0, 16'h10FF},  // R5 last legal offset, exec
    {3'd0, 12'h100, 2'd0, 2'd2, 16'h0000},  // R5 offset == limit
    {3'd0, 12'h010, 2'd1, 2'd3, 16'h0000},  // R6 write denied
    {3'd1, 12'h7FF, 2'd1, 2'd0, 16'h27FF},  // R8 write
    {3'd1, 12'h010, 2'd2, 2'd3, 16'h0000},  // R6 exec denied
    {3'd2, 12'hFFF, 2'd2, 2'd0, 16'hFFFF},  // R8 top of space
    {3'd2, 12'h001, 2'd3, 2'd3, 16'h0000},  // R6 reserved type
    {3'd3, 12'h000, 2'd0, 2'd2, 16'h0000},  // R4 invalid entry
    {3'd4, 12'h000, 2'd0, 2'd2, 16'h0000},  // R5 zero limit
    {3'd5, 12'h000, 2'd0, 2'd1, 16'h0000},  // R3 seg == len
    {3'd7, 12'h000, 2'd0, 2'd1, 16'h0000},  // R3 seg > len
    {3'd3, 12'h020, 2'd3, 2'd2, 16'h0000},  // R7 invalid beats perm
    {3'd1, 12'h900, 2'd2, 2'd2, 16'h0000}   // R7 limit beats perm
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 0, cfg_we = 0, cfg_len_sel = 0, cfg_valid = 0;
  logic [SEG_W-1:0] req_seg = '0, cfg_idx = '0;
  logic [OFS_W-1:0] req_ofs = '0;
  logic [1:0]       req_acc = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFS_W:0]   cfg_limit = '0;
  logic [2:0]       cfg_perm = '0;
  logic [SEG_W:0]   cfg_len = '0;
  logic rsp_valid, rsp_fault, mem_req;
  logic [1:0] rsp_cause;
  logic [PA_W-1:0] rsp_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_ofs_i(req_ofs), .req_acc_i(req_acc),
    .cfg_we_i(cfg_we), .cfg_len_sel_i(cfg_len_sel), .cfg_idx_i(cfg_idx),
    .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit), .cfg_valid_i(cfg_valid),
    .cfg_perm_i(cfg_perm), .cfg_len_i(cfg_len),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause),
    .rsp_paddr_o(rsp_paddr), .mem_req_o(mem_req)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // call at a negedge; sets config fields and raises we for one cycle
  task automatic set_entry(input int idx, input logic [PA_W-1:0] b, input logic [OFS_W:0] l,
                           input logic v, input logic [2:0] p);
    cfg_we = 1; cfg_len_sel = 0; cfg_idx = SEG_W'(idx);
    cfg_base = b; cfg_limit = l; cfg_valid = v; cfg_perm = p;
  endtask

  task automatic set_len(input logic [SEG_W:0] n);
    cfg_we = 1; cfg_len_sel = 1; cfg_len = n;
  endtask

  task automatic set_req(input logic [SEG_W-1:0] s, input logic [OFS_W-1:0] o, input logic [1:0] a);
    req_valid = 1; req_seg = s; req_ofs = o; req_acc = a;
  endtask

  // sample one cycle after a request driven at the previous negedge
  task automatic check_rsp(input string req, input logic [1:0] cause, input logic [PA_W-1:0] pa);
    check(req, "valid", 32'(rsp_valid), 1);
    check(req, "cause", 32'(rsp_cause), 32'(cause));
    check(req, "fault", 32'(rsp_fault), 32'(cause != 2'b00));
    check(req, "paddr", 32'(rsp_paddr), 32'(pa));
    check(req, "mem_req", 32'(mem_req), 32'(cause == 2'b00));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 outputs during reset
    repeat (3) @(negedge clk);
    check("R1", "rst valid", 32'(rsp_valid), 0);
    check("R1", "rst fault", 32'(rsp_fault), 0);
    check("R1", "rst mem_req", 32'(mem_req), 0);
    check("R1", "rst paddr", 32'(rsp_paddr), 0);
    check("R1", "rst cause", 32'(rsp_cause), 0);
    rst_ni = 1;
    @(negedge clk);
    // R1 length 0 after reset: any segment out of range
    set_req(3'd0, 12'h000, 2'd0);
    @(negedge clk);
    req_valid = 0;
    check_rsp("R1", 2'b01, 16'h0);
    @(negedge clk);
    check("R2", "idle valid", 32'(rsp_valid), 0);

    set_entry(0, 16'h1000, 13'h0100, 1, 3'b101); @(negedge clk);
    set_entry(1, 16'h2000, 13'h0800, 1, 3'b011); @(negedge clk);
    set_entry(2, 16'hF000, 13'h1000, 1, 3'b111); @(negedge clk);
    set_entry(3, 16'h3000, 13'h0010, 0, 3'b111); @(negedge clk);
    set_entry(4, 16'h4000, 13'h0000, 1, 3'b111); @(negedge clk);
    set_len(4'd5); @(negedge clk);
    cfg_we = 0;

    for (int i = 0; i < NV; i++) begin
      set_req(VEC[i][34:32], VEC[i][31:20], VEC[i][19:18]);
      @(negedge clk);
      req_valid = 0;
      check_rsp($sformatf("vec%0d", i), VEC[i][17:16], VEC[i][15:0]);
    end

    // R10 entry write in the same cycle as a lookup of that entry
    set_req(3'd3, 12'h005, 2'd0);
    set_entry(3, 16'h3000, 13'h0010, 1, 3'b111);
    @(negedge clk);
    cfg_we = 0;
    check_rsp("R10 same-cycle entry", 2'b10, 16'h0);
    set_req(3'd3, 12'h005, 2'd0);
    @(negedge clk);
    req_valid = 0;
    check_rsp("R10 next entry", 2'b00, 16'h3005);

    // R10 length write in the same cycle as a lookup
    set_req(3'd5, 12'h000, 2'd0);
    set_len(4'd6);
    @(negedge clk);
    cfg_we = 0;
    check_rsp("R10 same-cycle len", 2'b01, 16'h0);
    set_req(3'd5, 12'h000, 2'd0);
    @(negedge clk);
    req_valid = 0;
    check_rsp("R11 len only, entry5 still invalid", 2'b10, 16'h0);

    // R11 length write leaves entries untouched
    set_req(3'd1, 12'h123, 2'd0);
    @(negedge clk);
    req_valid = 0;
    check_rsp("R11 entry1 kept", 2'b00, 16'h2123);

    // R11 entry write leaves length untouched
    set_entry(7, 16'h7000, 13'h0100, 1, 3'b111); @(negedge clk);
    cfg_we = 0;
    set_req(3'd7, 12'h000, 2'd0);
    @(negedge clk);
    req_valid = 0;
    check_rsp("R11 len kept at 6", 2'b01, 16'h0);
    @(negedge clk);
    check("R2", "idle after burst", 32'(rsp_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule